// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a one-word-per-line direct-mapped cache placed in front of a next-level memory port. A small fully-associative victim buffer sits between the two. Lines that leave the main array are parked in the buffer rather than being discarded. A later request for a parked line swaps it back into the main array, and the line it displaces takes its buffer slot. Two blocks that share an index and are used alternately therefore stop thrashing once both have been fetched.

A request carries a block address and, for a write, one data word. The low address bits select the main-array line and the upper bits form the tag. The block accepts one request at a time. It answers with one response pulse that is flagged either hit or miss and carries the line contents after the access. A miss in both structures raises a one-cycle fill request toward memory and then waits for the fill word. When that fill pushes an older modified line out of the full buffer, the block emits a one-cycle write-back beat.

Top module: `vcache_top`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, mem_rd_req and mem_wb_valid are 0. No line is valid, so the first access to every block is a miss.
- R2: The block address splits into an index (its low 4 bits) and a tag (the remaining bits). A request whose tag matches the valid main line at its index responds with resp_hit in the first cycle after acceptance, and resp_rdata carries the line's latest data.
- R3: A main-array miss probes the victim buffer by full block address. A buffer hit responds with resp_hit in the second cycle after acceptance and raises no fill request.
- R4: On a buffer hit the requested line moves into the main array, and the displaced main line (address, data, dirty state) takes the same buffer slot. The next access to the moved line hits in one cycle, and the next access to the displaced line hits in two.
- R5: A miss in both structures raises mem_rd_req for exactly one cycle, in the third cycle after acceptance, with mem_rd_addr equal to the block address. The response, flagged resp_miss with resp_rdata equal to the fill word, comes in the cycle mem_fill_valid is high.
- R6: On a fill, a valid displaced main line is written into the victim buffer.
- R7: Insertions caused by fills use buffer slots 0 to 3 in rotating order. When all slots are valid, the slot whose turn comes next is overwritten. A swap rewrites its slot in place and does not move the rotation.
- R8: When an insertion overwrites a valid modified buffer entry, mem_wb_valid pulses in the fill-response cycle with that entry's address and data. Dropping a clean entry raises no write-back.
- R9: A write stores req_wdata into the line and marks it modified, whether it hits the main array, hits the buffer or misses. The modified state travels with the line through swaps and evictions.
- R10: Two blocks that share an index and are accessed alternately cause no fill request after the first fill of each.
- R11: req_ready is high only while the block is idle. It is low from the cycle after acceptance up to and including the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Block address (tag, index) |
| req_wdata | input | 32 | Write word |
| req_ready | output | 1 | Request accepted at this edge when valid |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Served by main array or victim buffer |
| resp_miss | output | 1 | Served by a next-level fill |
| resp_rdata | output | 32 | Line contents after the access |
| mem_rd_req | output | 1 | Fill request pulse |
| mem_rd_addr | output | 8 | Fill block address |
| mem_fill_valid | input | 1 | Fill word present |
| mem_fill_data | input | 32 | Fill word |
| mem_wb_valid | output | 1 | Write-back pulse |
| mem_wb_addr | output | 8 | Write-back block address |
| mem_wb_data | output | 32 | Write-back word |

## Verification
The bench ping-pongs two blocks on one index. A swap that forgets to return the displaced line to the buffer would show up there as repeated fill requests. It pushes six modified lines through one index so that the rotation wraps. A design with a wrong rotation or a lost dirty flag would either skip a write-back or send out the wrong address or word. Reads after write-backs refetch the evicted blocks, which catches a merge that dropped the write word. The bench also times every response against the one-, two- and fill-latency-dependent cycle counts, so a probe that ran in parallel or a fill request that repeated would be reported.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_PROBE = 3'd2,
    ST_FREQ  = 3'd3,
    ST_FWAIT = 3'd4
  } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  val_q;
  logic [LINES-1:0]  dty_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  // state bits: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
    end else if (wr_en) begin
      val_q[idx] <= 1'b1;
      dty_q[idx] <= wr_dirty;
    end
  end

  // payload: no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx] <= wr_tag;
      dat_q[idx] <= wr_data;
    end
  end

  assign rd_valid = val_q[idx];
  assign rd_dirty = dty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_data  = dat_q[idx];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 8,
  parameter int VB_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  lk_addr,
  output logic              lk_hit,
  output logic              lk_dirty,
  output logic [DATA_W-1:0] lk_data,
  output logic              ev_valid,
  output logic              ev_dirty,
  output logic [BLK_W-1:0]  ev_addr,
  output logic [DATA_W-1:0] ev_data,
  input  logic              wr_en,
  input  logic              wr_at_ptr,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [BLK_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SLOT_W = (VB_N > 1) ? $clog2(VB_N) : 1;

  logic [VB_N-1:0]   val_q;
  logic [VB_N-1:0]   dty_q;
  logic [BLK_W-1:0]  adr_q [VB_N];
  logic [DATA_W-1:0] dat_q [VB_N];
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [VB_N-1:0]   match;
  logic [SLOT_W-1:0] lk_slot, wr_slot;

  // one comparator per slot
  for (genvar g = 0; g < VB_N; g++) begin : g_cam
    assign match[g] = val_q[g] && (adr_q[g] == lk_addr);
  end

  always_comb begin
    lk_slot = '0;
    for (int i = VB_N - 1; i >= 0; i--) begin
      if (match[i]) lk_slot = SLOT_W'(i);
    end
  end

  assign lk_hit   = |match;
  assign lk_dirty = dty_q[lk_slot];
  assign lk_data  = dat_q[lk_slot];
  assign ev_valid = val_q[ptr_q];
  assign ev_dirty = dty_q[ptr_q];
  assign ev_addr  = adr_q[ptr_q];
  assign ev_data  = dat_q[ptr_q];
  assign wr_slot  = wr_at_ptr ? ptr_q : lk_slot;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_en && wr_at_ptr)
      ptr_d = (ptr_q == SLOT_W'(VB_N - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (wr_en) begin
        val_q[wr_slot] <= wr_valid;
        dty_q[wr_slot] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      adr_q[wr_slot] <= wr_addr;
      dat_q[wr_slot] <= wr_data;
    end
  end
endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 8,
  parameter int IDX_W  = 4,
  parameter int VB_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BLK_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_req,
  output logic [BLK_W-1:0]  mem_rd_addr,
  input  logic              mem_fill_valid,
  input  logic [DATA_W-1:0] mem_fill_data,
  output logic              mem_wb_valid,
  output logic [BLK_W-1:0]  mem_wb_addr,
  output logic [DATA_W-1:0] mem_wb_data
);
  import vc_pkg::*;
  localparam int TAG_W = BLK_W - IDX_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  vc_state_e         st_q, st_d;
  logic              q_wr;
  logic [BLK_W-1:0]  q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic              cap_en;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              m_valid, m_dirty, m_hit;
  logic [TAG_W-1:0]  m_tag;
  logic [DATA_W-1:0] m_data;
  logic              mw_en, mw_dirty;
  logic [DATA_W-1:0] mw_data;

  logic              v_hit, v_dirty, ev_valid, ev_dirty;
  logic [DATA_W-1:0] v_data;
  logic              vw_en, vw_at_ptr, vw_valid;

  assign idx   = q_addr[IDX_W-1:0];
  assign tag   = q_addr[BLK_W-1:IDX_W];
  assign m_hit = m_valid && (m_tag == tag);

  vc_main_array #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_main (
    .clk(clk), .rst_n(srst_n), .idx(idx),
    .wr_en(mw_en), .wr_dirty(mw_dirty), .wr_tag(tag), .wr_data(mw_data),
    .rd_valid(m_valid), .rd_dirty(m_dirty), .rd_tag(m_tag), .rd_data(m_data)
  );

  vc_victim_buf #(.DATA_W(DATA_W), .BLK_W(BLK_W), .VB_N(VB_N)) u_vbuf (
    .clk(clk), .rst_n(srst_n), .lk_addr(q_addr),
    .lk_hit(v_hit), .lk_dirty(v_dirty), .lk_data(v_data),
    .ev_valid(ev_valid), .ev_dirty(ev_dirty), .ev_addr(mem_wb_addr), .ev_data(mem_wb_data),
    .wr_en(vw_en), .wr_at_ptr(vw_at_ptr), .wr_valid(vw_valid),
    .wr_dirty(m_dirty), .wr_addr({m_tag, idx}), .wr_data(m_data)
  );

  // next-state and outputs
  always_comb begin
    st_d         = st_q;
    cap_en       = 1'b0;
    req_ready    = 1'b0;
    resp_valid   = 1'b0;
    resp_hit     = 1'b0;
    resp_miss    = 1'b0;
    mem_rd_req   = 1'b0;
    mem_wb_valid = 1'b0;
    mw_en        = 1'b0;
    mw_dirty     = 1'b0;
    mw_data      = m_data;
    vw_en        = 1'b0;
    vw_at_ptr    = 1'b0;
    vw_valid     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          cap_en = 1'b1;
          st_d   = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (m_hit) begin
          resp_valid = 1'b1;
          resp_hit   = 1'b1;
          mw_en      = q_wr;
          mw_dirty   = 1'b1;
          mw_data    = q_wr ? q_wdata : m_data;
          st_d       = ST_IDLE;
        end else begin
          st_d = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (v_hit) begin
          resp_valid = 1'b1;
          resp_hit   = 1'b1;
          mw_en      = 1'b1;
          mw_dirty   = v_dirty | q_wr;
          mw_data    = q_wr ? q_wdata : v_data;
          vw_en      = 1'b1;
          vw_valid   = m_valid;
          st_d       = ST_IDLE;
        end else begin
          st_d = ST_FREQ;
        end
      end
      ST_FREQ: begin
        mem_rd_req = 1'b1;
        st_d       = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (mem_fill_valid) begin
          resp_valid   = 1'b1;
          resp_miss    = 1'b1;
          mw_en        = 1'b1;
          mw_dirty     = q_wr;
          mw_data      = q_wr ? q_wdata : mem_fill_data;
          vw_en        = m_valid;
          vw_at_ptr    = 1'b1;
          vw_valid     = 1'b1;
          mem_wb_valid = m_valid && ev_valid && ev_dirty;
          st_d         = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      q_wr    <= req_write;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
    end
  end

  assign resp_rdata  = mw_data;
  assign mem_rd_addr = q_addr;
endmodule

// File: rtl/vc_chk.sv
module vc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_miss,
  input logic mem_rd_req,
  input logic mem_fill_valid,
  input logic mem_wb_valid
);
  // R11: busy right after acceptance
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R5: fill request lasts a single cycle
  a_r5_rdreq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  // R3: a hit never touches next-level memory
  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> !mem_rd_req && !mem_wb_valid);

  // R8: write-back only alongside a fill response
  a_r8_wb_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid |-> resp_valid && resp_miss && mem_fill_valid);

  // R2: a response carries exactly one outcome flag
  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_hit, resp_miss}) == 1);

  // R1: no outcome flag without a response
  a_r1_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !resp_hit && !resp_miss);
endmodule

bind vcache_top vc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
  .mem_rd_req(mem_rd_req), .mem_fill_valid(mem_fill_valid), .mem_wb_valid(mem_wb_valid)
);

// File: tb/tb_vcache_top.sv
module tb_vcache_top;
  localparam int CLK_P  = 10;
  localparam int MEMLAT = 2;
  localparam int LINES  = 16;
  localparam int VB_N   = 4;
  localparam int NBLK   = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, resp_valid, resp_hit, resp_miss;
  logic [31:0] resp_rdata;
  logic        mem_rd_req;
  logic [7:0]  mem_rd_addr;
  logic        mem_fill_valid;
  logic [31:0] mem_fill_data;
  logic        mem_wb_valid;
  logic [7:0]  mem_wb_addr;
  logic [31:0] mem_wb_data;

  vcache_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_rdata(resp_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data)
  );

  always #(CLK_P / 2) clk = ~clk;

  // reference state
  bit          m_v [LINES];
  bit          m_d [LINES];
  logic [3:0]  m_t [LINES];
  logic [31:0] m_x [LINES];
  bit          v_v [VB_N];
  bit          v_d [VB_N];
  logic [7:0]  v_a [VB_N];
  logic [31:0] v_x [VB_N];
  int          ptr;
  logic [31:0] mem [NBLK];

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // one request; cls: 0 main hit, 1 buffer hit, 2 miss
  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                        input string rq, output int cls);
    logic [3:0]  ix = a[3:0];
    logic [3:0]  tg = a[7:4];
    int          ecls, elat, slot, k, fill_at, rd_seen;
    bit          ewb, wb_seen, done;
    logic [7:0]  ewb_a;
    logic [31:0] ewb_d, edata, fill_d;
    ewb = 0; ewb_a = '0; ewb_d = '0; slot = -1;
    if (m_v[ix] && m_t[ix] == tg) begin
      ecls = 0; elat = 1;
      if (wr) begin m_x[ix] = wd; m_d[ix] = 1; end
      edata = m_x[ix];
    end else begin
      for (int s = 0; s < VB_N; s++) if (v_v[s] && v_a[s] == a) slot = s;
      if (slot >= 0) begin
        bit nd; logic [31:0] nx;
        ecls = 1; elat = 2;
        nd = v_d[slot] | wr; nx = wr ? wd : v_x[slot];
        v_v[slot] = m_v[ix]; v_d[slot] = m_d[ix]; v_a[slot] = {m_t[ix], ix}; v_x[slot] = m_x[ix];
        m_v[ix] = 1; m_d[ix] = nd; m_t[ix] = tg; m_x[ix] = nx;
        edata = nx;
      end else begin
        ecls = 2; elat = 3 + MEMLAT;
        if (m_v[ix]) begin
          if (v_v[ptr] && v_d[ptr]) begin
            ewb = 1; ewb_a = v_a[ptr]; ewb_d = v_x[ptr];
            mem[ewb_a] = ewb_d;
          end
          v_v[ptr] = 1; v_d[ptr] = m_d[ix]; v_a[ptr] = {m_t[ix], ix}; v_x[ptr] = m_x[ix];
          ptr = (ptr + 1) % VB_N;
        end
        m_v[ix] = 1; m_d[ix] = wr; m_t[ix] = tg; m_x[ix] = wr ? wd : mem[a];
        edata = m_x[ix];
      end
    end
    // drive request
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    chk("R11", "ready when idle", {31'b0, req_ready}, 32'd1);
    @(posedge clk); #1;
    req_valid = 0;
    k = 0; fill_at = -1; rd_seen = 0; wb_seen = 0; done = 0; fill_d = '0; cls = -1;
    while (!done && k < 40) begin
      k++;
      @(negedge clk);
      chk("R11", "ready while busy", {31'b0, req_ready}, 32'd0);
      if (mem_rd_req) begin
        rd_seen++;
        chk("R5", "fill addr", {24'b0, mem_rd_addr}, {24'b0, a});
        chk("R5", "fill request cycle", k, 3);
        fill_at = k + MEMLAT;
        fill_d  = mem[mem_rd_addr];
      end
      if (mem_wb_valid) begin
        wb_seen = 1;
        chk("R8", "write-back addr", {24'b0, mem_wb_addr}, {24'b0, ewb_a});
        chk("R8", "write-back data", mem_wb_data, ewb_d);
      end
      if (resp_valid) begin
        done = 1;
        cls  = resp_miss ? 2 : (resp_hit ? (k == 1 ? 0 : 1) : -1);
        chk(ecls == 0 ? "R2" : (ecls == 1 ? "R3" : "R5"), "response cycle", k, elat);
        chk(rq, "outcome hit/miss", {30'b0, resp_hit, resp_miss},
            {30'b0, ecls != 2, ecls == 2});
        chk(wr ? "R9" : (ecls == 1 ? "R4" : "R2"), "line data", resp_rdata, edata);
      end
      @(posedge clk); #1;
      mem_fill_valid = (k + 1 == fill_at);
      mem_fill_data  = fill_d;
    end
    mem_fill_valid = 0;
    chk("R8", "write-back presence", {31'b0, wb_seen}, {31'b0, ewb});
    chk(ecls == 2 ? "R5" : "R3", "fill request count", rd_seen, (ecls == 2) ? 1 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c, misses;
    logic [31:0] lcg;
    for (int i = 0; i < NBLK; i++) mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
    for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_d[i] = 0; m_t[i] = '0; m_x[i] = '0; end
    for (int i = 0; i < VB_N; i++) begin v_v[i] = 0; v_d[i] = 0; v_a[i] = '0; v_x[i] = '0; end
    ptr = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    mem_fill_valid = 0; mem_fill_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset ready", {31'b0, req_ready}, 32'd1);
    chk("R1", "reset resp_valid", {31'b0, resp_valid}, 32'd0);
    chk("R1", "reset mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
    chk("R1", "reset mem_wb_valid", {31'b0, mem_wb_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: cold sweep misses everywhere, then R2 hits
    for (int i = 0; i < LINES; i++) begin
      access(0, 8'(i), '0, "R1", c);
      chk("R1", "cold miss", c, 2);
    end
    for (int i = 0; i < LINES; i++) access(0, 8'(i), '0, "R2", c);

    // R10: ping-pong on one index
    access(1, 8'h15, 32'hC0DE_0015, "R6", c);
    misses = 0;
    for (int i = 0; i < 10; i++) begin
      access(i[0], (i % 2 == 0) ? 8'h05 : 8'h15, 32'h7700_0000 + i, "R4", c);
      if (c == 2) misses++;
    end
    chk("R10", "fills during ping-pong", misses, 0);

    // R7 and R8: overflow the buffer with modified lines at one index
    for (int t = 1; t < 8; t++) access(1, {4'(t), 4'h9}, 32'hD000_0000 + t, "R7", c);
    for (int t = 0; t < 8; t++) access(0, {4'(t), 4'h9}, '0, "R7", c);

    // R9: mixed sweep over three tags
    lcg = 32'h1234_5678;
    for (int n = 0; n < 900; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      access(lcg[31], {2'b0, 2'(lcg[20:16] % 3), lcg[11:8]}, lcg ^ 32'hA5A5_0000, "R9", c);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule